// File: doc/BRIEF.md
# Elastic Micro-Op Queue with Loop Replay

This block is a circular buffer of decoded micro-ops. It sits between an instruction-decode front-end and a rename stage. Each cycle, one of three producers may offer a group of micro-ops through a single valid/ready enqueue port: the legacy decoders, the decoded-op cache, or the microcode sequencer. A one-hot select names the producer, and each producer has its own group-size limit. A group is taken whole or not at all. When the free space is smaller than the offered count, `in_ready` drops and the producer must hold the group and retry. `in_ready` depends only on the offered count, the occupancy and the lock state. It never depends on `in_valid`.

On the drain side, the block presents the oldest micro-ops in program order on six output slots, each with its own valid bit. The consumer returns an accept count that says how many leading slots it took in that cycle. The consumer may accept zero slots to stall. Entries are freed only by that accept, and only outside loop-lock.

A loop-lock request names a body by its absolute start position and its length. When the body lies wholly inside the held entries, the block enters replay. In replay, the slots walk the body cyclically, nothing is freed, the enqueue port is closed, and a gate request tells the front-end it may clock-gate its decoders and op cache. Release resumes normal delivery from the queue head. Flush empties the queue and leaves loop-lock at once.

Top module: `uop_queue`

## Requirements
- R1: After reset, no output slot is valid, `gate_req` is low, and `in_ready` is high for any offered count from 0 to 6.
- R2: A group is written only when `in_valid` and `in_ready` are high, `in_src` has exactly one bit set, and `in_count` is within that source's limit. The bit positions are: bit 0 is the legacy decoders (limit 5), bit 1 is the op cache (limit 6), bit 2 is the microcode sequencer (limit 4). Otherwise nothing is stored.
- R3: Outside loop-lock, `in_ready` is high exactly when `in_count` is at most 64 minus the occupancy. A group is never partially stored.
- R4: Outside loop-lock, the valid slots are slots 0 up to min(occupancy,6)-1. Slot i carries the i-th oldest held micro-op.
- R5: Outside loop-lock, the leading min(`out_accept`, valid slots) entries are freed at the edge. The remaining entries move forward in order.
- R6: Entries are written to consecutive positions modulo 64, starting from position 0 after reset or flush. A lock request is granted when all of the following hold: the block is not locked, the length is between 1 and 64, d = (`lock_start` − head) mod 64 is at least the accept count of that cycle, and d + length is at most the occupancy. If granted, `gate_req` is high from the next cycle on. If not, the request has no effect.
- R7: In loop-lock, all six slots are valid. Slot i carries body entry (offset+i) mod length. The offset starts at 0 and advances by the accept count modulo the length. The occupancy does not change.
- R8: In loop-lock, `in_ready` is low and nothing is written.
- R9: `lock_release` in loop-lock drops `gate_req` on the next cycle. Delivery then resumes at the queue head, with all held entries still present.
- R10: `flush` overrides every other input. From the next cycle, the queue is empty, loop-lock is off and `gate_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the queue and leave loop-lock |
| in_valid | input | 1 | Enqueue group offered |
| in_src | input | 3 | One-hot producer select (bit0 legacy, bit1 op cache, bit2 microcode) |
| in_count | input | 3 | Micro-ops in the offered group |
| in_data | input | 96 | Six 16-bit micro-op lanes, lane 0 oldest |
| in_ready | output | 1 | Whole offered group fits and the port is open |
| out_valid | output | 6 | Per-slot valid |
| out_data | output | 96 | Six 16-bit output slots, slot 0 oldest |
| out_accept | input | 3 | Number of leading slots taken this cycle |
| lock_req | input | 1 | Request loop-lock |
| lock_start | input | 6 | Absolute position of the first body entry |
| lock_len | input | 7 | Body length in micro-ops |
| lock_release | input | 1 | Leave loop-lock |
| gate_req | output | 1 | Front-end may clock-gate decoders and op cache |

## Verification
A corrupted head pointer or occupancy shows at the ports in the same cycle. The slot data no longer follows the enqueue order, the valid prefix has the wrong length, or `in_ready` flips at the wrong fill level. A wrong replay offset or body bound shows in the first replay cycle whose slots wrap past the body end. A lost or stuck lock bit shows one cycle after the request or release, on `gate_req` and on the all-valid replay slots. The bench models the queue and compares every slot, `in_ready` and `gate_req` on every cycle, so each such fault is reported at its first visible cycle.

// File: rtl/uq_pkg.sv
package uq_pkg;
  // Bit positions inside the one-hot producer select
  localparam int SRC_N      = 3;
  localparam int SRC_LEGACY = 0;
  localparam int SRC_CACHE  = 1;
  localparam int SRC_UCODE  = 2;
endpackage

// File: rtl/uq_admit.sv
module uq_admit
  import uq_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int LIM_LEGACY = 5,
  parameter int LIM_CACHE  = 6,
  parameter int LIM_UCODE  = 4,
  parameter int CNT_W      = 7,
  parameter int NUM_W      = 3
) (
  input  logic             in_valid,
  input  logic [SRC_N-1:0] in_src,
  input  logic [NUM_W-1:0] in_count,
  input  logic [CNT_W-1:0] occ,
  input  logic             locked,
  output logic             in_ready,
  output logic             wr_en
);
  int   limit;
  int   free_slots;
  logic src_ok;

  always_comb begin
    src_ok = ($countones(in_src) == 1);
    limit  = 0;
    if (in_src[SRC_LEGACY])     limit = LIM_LEGACY;
    else if (in_src[SRC_CACHE]) limit = LIM_CACHE;
    else if (in_src[SRC_UCODE]) limit = LIM_UCODE;
    free_slots = DEPTH - int'(occ);
    // ready is independent of in_valid; whole group or nothing
    in_ready = !locked && (int'(in_count) <= free_slots);
    wr_en    = in_valid && in_ready && src_ok && (int'(in_count) <= limit);
  end
endmodule

// File: rtl/uq_store.sv
module uq_store #(
  parameter int DEPTH  = 64,
  parameter int DW     = 16,
  parameter int SLOT_N = 6,
  parameter int PTR_W  = 6,
  parameter int NUM_W  = 3
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [PTR_W-1:0]        wr_ptr,
  input  logic [NUM_W-1:0]        wr_count,
  input  logic [SLOT_N*DW-1:0]    wr_data,
  input  logic [SLOT_N*PTR_W-1:0] rd_addr,
  output logic [SLOT_N*DW-1:0]    rd_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int j = 0; j < SLOT_N; j++) begin
        if (j < int'(wr_count)) mem[wr_ptr + PTR_W'(j)] <= wr_data[j*DW +: DW];
      end
    end
  end

  for (genvar k = 0; k < SLOT_N; k++) begin : g_rd
    assign rd_data[k*DW +: DW] = mem[rd_addr[k*PTR_W +: PTR_W]];
  end
endmodule

// File: rtl/uq_read.sv
module uq_read #(
  parameter int SLOT_N = 6,
  parameter int PTR_W  = 6,
  parameter int CNT_W  = 7,
  parameter int NUM_W  = 3
) (
  input  logic                    locked,
  input  logic [PTR_W-1:0]        head,
  input  logic [CNT_W-1:0]        occ,
  input  logic [PTR_W-1:0]        lk_start,
  input  logic [CNT_W-1:0]        lk_len,
  input  logic [CNT_W-1:0]        lk_off,
  input  logic [NUM_W-1:0]        accept_req,
  output logic [SLOT_N*PTR_W-1:0] rd_addr,
  output logic [SLOT_N-1:0]       slot_valid,
  output logic [NUM_W-1:0]        acc_eff,
  output logic [CNT_W-1:0]        next_off
);
  // offc[k]: body offset seen by slot k during replay, wrapping at lk_len
  logic [CNT_W-1:0] offc [SLOT_N+1];
  assign offc[0] = lk_off;

  for (genvar k = 0; k < SLOT_N; k++) begin : g_slot
    logic [CNT_W-1:0] inc;
    assign inc         = offc[k] + 1'b1;
    assign offc[k+1]   = (inc == lk_len) ? '0 : inc;
    assign rd_addr[k*PTR_W +: PTR_W] = locked ? lk_start + offc[k][PTR_W-1:0]
                                              : head + PTR_W'(k);
    assign slot_valid[k] = locked | (occ > CNT_W'(k));
  end

  int nvalid;
  int acc_i;
  always_comb begin
    nvalid = locked ? SLOT_N : ((int'(occ) < SLOT_N) ? int'(occ) : SLOT_N);
    acc_i  = (int'(accept_req) < nvalid) ? int'(accept_req) : nvalid;
    acc_eff = NUM_W'(acc_i);
    next_off = lk_off;
    for (int k = 0; k <= SLOT_N; k++) begin
      if (k == acc_i) next_off = offc[k];
    end
  end
endmodule

// File: rtl/uop_queue.sv
module uop_queue
  import uq_pkg::*;
#(
  parameter  int DEPTH      = 64,
  parameter  int DW         = 16,
  parameter  int SLOT_N     = 6,
  parameter  int LIM_LEGACY = 5,
  parameter  int LIM_CACHE  = 6,
  parameter  int LIM_UCODE  = 4,
  localparam int PTR_W      = $clog2(DEPTH),
  localparam int CNT_W      = PTR_W + 1,
  localparam int NUM_W      = $clog2(SLOT_N + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 in_valid,
  input  logic [SRC_N-1:0]     in_src,
  input  logic [NUM_W-1:0]     in_count,
  input  logic [SLOT_N*DW-1:0] in_data,
  output logic                 in_ready,
  output logic [SLOT_N-1:0]    out_valid,
  output logic [SLOT_N*DW-1:0] out_data,
  input  logic [NUM_W-1:0]     out_accept,
  input  logic                 lock_req,
  input  logic [PTR_W-1:0]     lock_start,
  input  logic [CNT_W-1:0]     lock_len,
  input  logic                 lock_release,
  output logic                 gate_req
);
  logic [PTR_W-1:0] head;
  logic [CNT_W-1:0] occ;
  logic             lock_active;
  logic [PTR_W-1:0] lk_start;
  logic [CNT_W-1:0] lk_len;
  logic [CNT_W-1:0] lk_off;

  logic                    wr_en;
  logic [PTR_W-1:0]        wr_ptr;
  logic [SLOT_N*PTR_W-1:0] rd_addr;
  logic [NUM_W-1:0]        acc;
  logic [CNT_W-1:0]        next_off;
  logic                    grant;
  int                      rel;

  assign wr_ptr   = head + occ[PTR_W-1:0];
  assign gate_req = lock_active;

  uq_admit #(
    .DEPTH(DEPTH), .LIM_LEGACY(LIM_LEGACY), .LIM_CACHE(LIM_CACHE),
    .LIM_UCODE(LIM_UCODE), .CNT_W(CNT_W), .NUM_W(NUM_W)
  ) u_admit (
    .in_valid(in_valid), .in_src(in_src), .in_count(in_count), .occ(occ),
    .locked(lock_active), .in_ready(in_ready), .wr_en(wr_en)
  );

  uq_store #(
    .DEPTH(DEPTH), .DW(DW), .SLOT_N(SLOT_N), .PTR_W(PTR_W), .NUM_W(NUM_W)
  ) u_store (
    .clk(clk), .wr_en(wr_en), .wr_ptr(wr_ptr), .wr_count(in_count),
    .wr_data(in_data), .rd_addr(rd_addr), .rd_data(out_data)
  );

  uq_read #(
    .SLOT_N(SLOT_N), .PTR_W(PTR_W), .CNT_W(CNT_W), .NUM_W(NUM_W)
  ) u_read (
    .locked(lock_active), .head(head), .occ(occ), .lk_start(lk_start),
    .lk_len(lk_len), .lk_off(lk_off), .accept_req(out_accept),
    .rd_addr(rd_addr), .slot_valid(out_valid), .acc_eff(acc), .next_off(next_off)
  );

  // Body must sit inside what remains after this cycle's drain
  always_comb begin
    rel   = int'(lock_start - head);
    grant = !lock_active && lock_req && (lock_len != '0)
         && (int'(lock_len) <= DEPTH) && (rel >= int'(acc))
         && (rel + int'(lock_len) <= int'(occ));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      head        <= '0;
      occ         <= '0;
      lock_active <= 1'b0;
      lk_start    <= '0;
      lk_len      <= '0;
      lk_off      <= '0;
    end else if (lock_active) begin
      lk_off <= next_off;
      if (lock_release) lock_active <= 1'b0;
    end else begin
      head <= head + PTR_W'(acc);
      occ  <= occ - CNT_W'(acc) + (wr_en ? CNT_W'(in_count) : '0);
      if (grant) begin
        lock_active <= 1'b1;
        lk_start    <= lock_start;
        lk_len      <= lock_len;
        lk_off      <= '0;
      end
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) <= DEPTH);
  a_r8_no_write_locked: assert property (@(posedge clk) disable iff (!rst_n)
    lock_active |-> !wr_en);
  a_r7_occ_held: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_active && !flush) |=> (occ == $past(occ)));
  a_r10_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (occ == '0) && !gate_req);
  a_r9_release_drops_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_active && lock_release) |=> !gate_req);
  a_r4_valid_prefix: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_active |-> ((out_valid & (out_valid + 1'b1)) == '0));
  a_r6_body_fits: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_active) |-> (lk_len != '0) && (lk_len <= occ));
endmodule

// File: tb/uop_queue_test.sv
`timescale 1ns/1ps
module uop_queue_test;
  localparam int DW = 16;
  localparam int SN = 6;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, flush, in_valid, in_ready, lock_req, lock_release, gate_req;
  logic [2:0] in_src, in_count, out_accept;
  logic [SN*DW-1:0] in_data, out_data;
  logic [SN-1:0] out_valid;
  logic [5:0] lock_start;
  logic [6:0] lock_len;

  uop_queue uut (.*);

  int n_cmp = 0, n_bad = 0;
  logic [DW-1:0] mm [DEPTH];
  int mhead = 0, mcount = 0, mstart = 0, mlen = 1, moff = 0;
  bit mlock = 0, prev_fl = 0;

  task automatic expect_eq(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int src_lim(logic [2:0] s);
    case (s)
      3'b001: return 5;
      3'b010: return 6;
      3'b100: return 4;
      default: return -1;
    endcase
  endfunction

  task automatic check_outputs();
    int ev, ed;
    if (prev_fl) begin
      expect_eq("R10 no valid slot after flush", int'(out_valid), 0);
      expect_eq("R10 gate low after flush", int'(gate_req), 0);
    end
    expect_eq(mlock ? "R8 in_ready" : "R3 in_ready", int'(in_ready),
              int'(!mlock && int'(in_count) <= DEPTH - mcount));
    for (int i = 0; i < SN; i++) begin
      ev = mlock ? 1 : int'(i < mcount);
      expect_eq(mlock ? "R7 slot valid" : "R4 slot valid", int'(out_valid[i]), ev);
      if (ev != 0) begin
        ed = mlock ? int'(mm[(mstart + (moff + i) % mlen) % DEPTH])
                   : int'(mm[(mhead + i) % DEPTH]);
        expect_eq(mlock ? "R7 replay data" : "R2/R4/R5 slot data",
                  int'(out_data[i*DW +: DW]), ed);
      end
    end
    expect_eq("R6/R9 gate_req", int'(gate_req), int'(mlock));
  endtask

  task automatic model_step();
    int nv, a, rel, tail;
    bit wr, gr;
    if (flush) begin
      mhead = 0; mcount = 0; mlock = 0; moff = 0;
      return;
    end
    nv = mlock ? SN : (mcount < SN ? mcount : SN);
    a  = int'(out_accept) < nv ? int'(out_accept) : nv;
    wr = in_valid && !mlock && (int'(in_count) <= DEPTH - mcount)
         && (int'(in_count) <= src_lim(in_src));
    rel = ((int'(lock_start) - mhead) % DEPTH + DEPTH) % DEPTH;
    gr = !mlock && lock_req && lock_len >= 1 && int'(lock_len) <= DEPTH
         && rel >= a && rel + int'(lock_len) <= mcount;
    tail = (mhead + mcount) % DEPTH;
    if (mlock) begin
      moff = (moff + a) % mlen;
      if (lock_release) mlock = 0;
    end else begin
      mhead = (mhead + a) % DEPTH;
      mcount = mcount - a;
    end
    if (wr) begin
      for (int j = 0; j < int'(in_count); j++) mm[(tail + j) % DEPTH] = in_data[j*DW +: DW];
      mcount = mcount + int'(in_count);
    end
    if (gr) begin
      mlock = 1; mstart = int'(lock_start); mlen = int'(lock_len); moff = 0;
    end
  endtask

  task automatic drive(bit v, logic [2:0] s, int c, int a, bit lr, int ls, int ll,
                       bit rl, bit fl);
    @(negedge clk);
    in_valid = v; in_src = s; in_count = 3'(c); out_accept = 3'(a);
    for (int j = 0; j < SN; j++) in_data[j*DW +: DW] = 16'($urandom);
    lock_req = lr; lock_start = 6'(ls); lock_len = 7'(ll);
    lock_release = rl; flush = fl;
    #2;
    check_outputs();
    model_step();
    prev_fl = fl;
  endtask

  task automatic rnd(int acc_mod, int v_pct, int lock_pct);
    logic [2:0] s;
    int sel;
    sel = $urandom % 3;
    s = ($urandom % 10 == 0) ? 3'($urandom) : 3'(1 << sel);
    drive(($urandom % 100) < v_pct, s, $urandom % 7, $urandom % acc_mod,
          ($urandom % 100) < lock_pct, (mhead + $urandom % 8) % DEPTH,
          ($urandom % 10 == 0) ? 65 + $urandom % 10 : 1 + $urandom % 12,
          mlock && ($urandom % 12 == 0), ($urandom % 250 == 0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all R): actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd5281));
    rst_n = 0; flush = 0; in_valid = 0; in_src = 3'b001; in_count = 3'd6;
    in_data = '0; out_accept = 0; lock_req = 0; lock_start = 0; lock_len = 0;
    lock_release = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #2;
    expect_eq("R1 no valid slot after reset", int'(out_valid), 0);
    expect_eq("R1 gate low after reset", int'(gate_req), 0);
    expect_eq("R1 ready for six", int'(in_ready), 1);

    // fill-biased and drain-biased random traffic
    for (int i = 0; i < 400; i++) rnd(3, 90, 3);
    for (int i = 0; i < 300; i++) rnd(8, 30, 3);

    // R3 boundary: fill to exactly 60, reject 6, accept 4
    drive(0, 3'b001, 0, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 10; i++) drive(1, 3'b010, 6, 0, 0, 0, 0, 0, 0);
    expect_eq("R3 occupancy sixty", mcount, 60);
    drive(1, 3'b010, 6, 0, 0, 0, 0, 0, 0);
    drive(1, 3'b100, 4, 0, 0, 0, 0, 0, 0);
    drive(1, 3'b001, 1, 0, 0, 0, 0, 0, 0);
    // R2 illegal groups: over-limit and two-hot select
    drive(0, 3'b001, 0, 6, 0, 0, 0, 0, 0);
    drive(0, 3'b001, 0, 6, 0, 0, 0, 0, 0);
    drive(1, 3'b001, 6, 0, 0, 0, 0, 0, 0);
    drive(1, 3'b100, 5, 0, 0, 0, 0, 0, 0);
    drive(1, 3'b011, 2, 0, 0, 0, 0, 0, 0);
    drive(0, 3'b001, 0, 0, 0, 0, 0, 0, 0);
    expect_eq("R2 illegal groups not stored", mcount, 52);

    // R6/R7/R8/R9 short body, replay with blocked enqueue, release
    drive(0, 3'b001, 0, 0, 1, (mhead + 2) % DEPTH, 3, 0, 0);
    for (int i = 0; i < 12; i++) drive(1, 3'b010, 1, $urandom % 7, 0, 0, 0, 0, 0);
    drive(0, 3'b001, 0, 2, 0, 0, 0, 1, 0);
    for (int i = 0; i < 3; i++) drive(0, 3'b001, 0, 1, 0, 0, 0, 0, 0);
    // R6 too-long bodies refused
    drive(0, 3'b001, 0, 0, 1, mhead, 65, 0, 0);
    drive(0, 3'b001, 0, 0, 1, mhead, mcount + 1, 0, 0);
    drive(0, 3'b001, 0, 0, 0, 0, 0, 0, 0);
    expect_eq("R6 long body refused", int'(gate_req), 0);
    // whole held content as body, then flush inside lock
    drive(0, 3'b001, 0, 0, 1, mhead, mcount, 0, 0);
    for (int i = 0; i < 8; i++) drive(0, 3'b001, 0, 6, 0, 0, 0, 0, 0);
    drive(0, 3'b001, 0, 3, 0, 0, 0, 0, 1);
    drive(0, 3'b001, 0, 0, 0, 0, 0, 0, 0);

    for (int i = 0; i < 2000; i++) rnd(i % 2 == 0 ? 4 : 8, 70, 6);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule